// File: doc/BRIEF.md
# Digital Input Terminal Conditioner

This block prepares seven raw digital inputs before control logic acts on them. Five are switch contacts and two are digital levels derived from analog channels. Each input goes through three stages in turn. First a per-input polarity bit sets which contact state counts as active. Next a shared sampling filter is clocked by a millisecond timebase. Last, the first four switch inputs pass through separate delays for turning active and for turning inactive, counted in milliseconds.

The filter samples every input once per programmed number of timebase ticks. It moves its output only when two samples in a row agree. A setting of zero bypasses the filter. If the filtered level returns to its earlier value while a delay is running, the pending change is dropped. Any new change then starts counting from zero.

Top module: `din_cond`

## Requirements
- R1: A raw level of 1 means the contact is closed. The active flag of an input equals its raw level XOR its polarity bit. Switch input k (k = 0..4) uses `pol_sw` bit k. Analog-derived input k (k = 0..1) uses `pol_ai` bit k. `pol_sw[7:5]` and `pol_ai[7:2]` have no effect.
- R2: With `filt_ms` = 0 the filter is bypassed. With all delays zero, each output takes its new polarised value at the first rising clock edge after an input change.
- R3: With `filt_ms` = n > 0, the inputs are sampled on every n-th `tick_ms` pulse, counted from reset. A filtered bit changes only when two consecutive samples agree. From reset, a steady active input therefore shows after exactly 2n ticks.
- R4: A single sample that disagrees with the previous sample leaves the filtered output unchanged, whether the output is low or high.
- R5: On switch inputs 0..3, a filtered rise with a nonzero active delay D becomes visible at the D-th tick after the rise. Delay k is `dly_on[15k+14:15k]`.
- R6: On switch inputs 0..3, a filtered fall with a nonzero inactive delay D becomes visible at the D-th tick after the fall. Delay k is `dly_off[15k+14:15k]`.
- R7: If the filtered level returns before a pending delay expires, the change is cancelled. The next change counts its full delay again from zero.
- R8: A zero delay passes the filtered value straight through. Switch input 4 and both analog-derived inputs always pass the filtered value through.
- R9: A delay value above 30000 acts as 30000.
- R10: During and right after reset every output is inactive and all counters are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| sw_raw | input | 5 | Raw switch contact levels, 1 = closed |
| ai_raw | input | 2 | Raw analog-derived digital levels |
| pol_sw | input | 8 | Polarity bits of the switch inputs |
| pol_ai | input | 8 | Polarity bits of the analog-derived inputs |
| filt_ms | input | 7 | Filter sampling interval in ticks, 0 = bypass |
| dly_on | input | 60 | Four 15-bit active-going delays |
| dly_off | input | 60 | Four 15-bit inactive-going delays |
| act_sw | output | 5 | Conditioned switch flags |
| act_ai | output | 2 | Conditioned analog-derived flags |

## Verification
The bench uses the default parameters: five switch inputs, two analog-derived inputs, four delayed inputs, 15-bit delays and a 30000 limit. Because the bench drives `tick_ms` directly every other cycle, a full 30000-tick delay fits in the run, so the clamp is checked at its exact edge. With only seven inputs, the polarity check can sweep all 128 input patterns under several polarity words. Filter intervals of 1, 2, 3 and 7 show the 2n-tick arrival time.

// File: rtl/din_cond.sv
module din_cond #(
  parameter int NSW  = 5,
  parameter int NAI  = 2,
  parameter int NDLY = 4,
  parameter int DW   = 15,
  parameter int FW   = 7,
  parameter int DMAX = 30000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_ms,
  input  logic [NSW-1:0]     sw_raw,
  input  logic [NAI-1:0]     ai_raw,
  input  logic [7:0]         pol_sw,
  input  logic [7:0]         pol_ai,
  input  logic [FW-1:0]      filt_ms,
  input  logic [NDLY*DW-1:0] dly_on,
  input  logic [NDLY*DW-1:0] dly_off,
  output logic [NSW-1:0]     act_sw,
  output logic [NAI-1:0]     act_ai
);
  localparam int NT = NSW + NAI;

  logic [NT-1:0]      level, samp, filt_q, agree, act;
  logic [NDLY-1:0]    st;
  logic [NDLY*DW-1:0] lim_f, cnt_f;
  logic [FW-1:0]      tcnt;
  logic               strobe;

  assign level  = {ai_raw ^ pol_ai[NAI-1:0], sw_raw ^ pol_sw[NSW-1:0]};
  assign strobe = tick_ms && (filt_ms != '0) && (tcnt >= filt_ms - FW'(1));
  assign agree  = ~(samp ^ level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt   <= '0;
      samp   <= '0;
      filt_q <= '0;
    end else if (filt_ms == '0) begin
      tcnt   <= '0;
      samp   <= level;
      filt_q <= level;
    end else if (tick_ms) begin
      tcnt <= strobe ? '0 : tcnt + FW'(1);
      if (strobe) begin
        samp   <= level;
        filt_q <= (agree & level) | (~agree & filt_q);
      end
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_term
    if (i < NDLY) begin : g_dly
      logic [DW-1:0] on_c, off_c, lim, cnt;
      assign on_c  = (dly_on[i*DW +: DW]  > DW'(DMAX)) ? DW'(DMAX) : dly_on[i*DW +: DW];
      assign off_c = (dly_off[i*DW +: DW] > DW'(DMAX)) ? DW'(DMAX) : dly_off[i*DW +: DW];
      assign lim   = st[i] ? off_c : on_c;
      assign act[i] = (lim == '0) ? filt_q[i] : st[i];
      assign lim_f[i*DW +: DW] = lim;
      assign cnt_f[i*DW +: DW] = cnt;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st[i] <= 1'b0;
          cnt   <= '0;
        end else if (filt_q[i] == st[i]) begin
          cnt <= '0;
        end else if (lim == '0) begin
          st[i] <= filt_q[i];
          cnt   <= '0;
        end else if (tick_ms) begin
          if (cnt >= lim - DW'(1)) begin
            st[i] <= filt_q[i];
            cnt   <= '0;
          end else begin
            cnt <= cnt + DW'(1);
          end
        end
      end
    end else begin : g_pass
      assign act[i] = filt_q[i];
    end
  end

  assign act_sw = act[NSW-1:0];
  assign act_ai = act[NT-1:NSW];
endmodule

// File: rtl/din_cond_chk.sv
module din_cond_chk #(
  parameter int NT   = 7,
  parameter int NDLY = 4,
  parameter int DW   = 15,
  parameter int FW   = 7,
  parameter int DMAX = 30000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_ms,
  input logic [FW-1:0]      filt_ms,
  input logic [NT-1:0]      level,
  input logic [NT-1:0]      filt_q,
  input logic [NT-1:0]      act,
  input logic [NDLY-1:0]    st,
  input logic [NDLY*DW-1:0] lim_f,
  input logic [NDLY*DW-1:0] cnt_f
);
  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_ms == '0) |=> (filt_q == $past(level)));

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_ms != '0 && !tick_ms) |=> $stable(filt_q));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (act == '0 && st == '0 && cnt_f == '0));

  for (genvar i = 0; i < NDLY; i++) begin : g_chk
    p_wait_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_ms && lim_f[i*DW +: DW] != '0) |=> $stable(st[i]));

    p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_q[i] == st[i]) |=> (cnt_f[i*DW +: DW] == '0));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_f[i*DW +: DW] < DW'(DMAX));
  end
endmodule

bind din_cond din_cond_chk #(
  .NT(NSW + NAI), .NDLY(NDLY), .DW(DW), .FW(FW), .DMAX(DMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .filt_ms(filt_ms),
  .level(level), .filt_q(filt_q), .act(act), .st(st),
  .lim_f(lim_f), .cnt_f(cnt_f)
);

// File: tb/test_din_cond.sv
module test_din_cond;
  logic        clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0;
  logic [4:0]  sw_raw = '0;
  logic [1:0]  ai_raw = '0;
  logic [7:0]  pol_sw = '0, pol_ai = '0;
  logic [6:0]  filt_ms = '0;
  logic [59:0] dly_on = '0, dly_off = '0;
  logic [4:0]  act_sw;
  logic [1:0]  act_ai;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  din_cond i_din_cond (.clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .sw_raw(sw_raw),
    .ai_raw(ai_raw), .pol_sw(pol_sw), .pol_ai(pol_ai), .filt_ms(filt_ms),
    .dly_on(dly_on), .dly_off(dly_off), .act_sw(act_sw), .act_ai(act_ai));

  task automatic chk(input string r, input logic [6:0] exp);
    n_chk++;
    if ({act_ai, act_sw} !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", r, {act_ai, act_sw}, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #950000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
  end

  initial begin
    // R10: outputs inactive while in reset, even with every input active
    sw_raw = '1; ai_raw = '1;
    repeat (3) @(negedge clk);
    chk("R10 in reset", 7'h00);
    do_reset();
    chk("R10 after release", 7'h00);

    // R1, R2: full sweep, bypass filter, ignored polarity bits set
    for (int p = 0; p < 4; p++) begin
      logic [7:0] ps, pa;
      ps = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h0A;
      pa = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h5A : 8'h01;
      pol_sw = ps; pol_ai = pa;
      for (int v = 0; v < 128; v++) begin
        {ai_raw, sw_raw} = 7'(v);
        @(negedge clk);
        chk("R1 R2 polarity sweep", 7'(v) ^ {pa[1:0], ps[4:0]});
      end
    end
    pol_sw = '0; pol_ai = '0;

    // R3: steady input appears after exactly 2n ticks
    for (int q = 0; q < 4; q++) begin
      int n;
      n = (q == 0) ? 1 : (q == 1) ? 2 : (q == 2) ? 3 : 7;
      sw_raw = '0; ai_raw = '0; filt_ms = 7'(n);
      do_reset();
      sw_raw = 5'b10000; ai_raw = 2'b10;
      ticks(2 * n - 1);
      chk("R3 before 2n ticks", 7'h00);
      ticks(1);
      chk("R3 at 2n ticks", 7'b1010000);
    end

    // R4: single disagreeing samples are rejected (n = 2)
    sw_raw = '0; ai_raw = '0; filt_ms = 7'd2;
    do_reset();
    ai_raw = 2'b01; ticks(2);
    ai_raw = 2'b00; ticks(2);
    chk("R4 lone high sample", 7'h00);
    ai_raw = 2'b01; ticks(4);
    chk("R4 settle high", 7'b0100000);
    ai_raw = 2'b00; ticks(2);
    ai_raw = 2'b01; ticks(2);
    chk("R4 lone low sample", 7'b0100000);

    // R5, R6, R8: per-terminal delays, filter bypassed
    filt_ms = '0; sw_raw = '0; ai_raw = '0;
    for (int t = 0; t < 4; t++) begin
      dly_on[t*15 +: 15]  = 15'(t + 1);
      dly_off[t*15 +: 15] = 15'(t + 2);
    end
    do_reset();
    for (int t = 0; t < 4; t++) begin
      @(negedge clk) sw_raw[t] = 1'b1;
      if (t > 0) begin
        ticks(t);
        chk("R5 before active delay", 7'h00);
      end
      ticks(1);
      chk("R5 at active delay", 7'(1 << t));
      @(negedge clk) sw_raw[t] = 1'b0;
      ticks(t + 1);
      chk("R6 before inactive delay", 7'(1 << t));
      ticks(1);
      chk("R6 at inactive delay", 7'h00);
    end

    // R8: zero delay passes immediately
    dly_on = '0; dly_off = '0;
    @(negedge clk) sw_raw = 5'b01111;
    @(negedge clk);
    chk("R8 zero delay rise", 7'b0001111);
    sw_raw = 5'b00000;
    @(negedge clk);
    chk("R8 zero delay fall", 7'h00);

    // R7: cancel and restart on X2 (active delay 5)
    dly_on[15 +: 15] = 15'd5;
    @(negedge clk) sw_raw[1] = 1'b1;
    ticks(3);
    @(negedge clk) sw_raw[1] = 1'b0;
    ticks(3);
    chk("R7 cancelled", 7'h00);
    sw_raw[1] = 1'b1;
    ticks(4);
    chk("R7 restart not yet", 7'h00);
    ticks(1);
    chk("R7 restart full delay", 7'b0000010);
    @(negedge clk) sw_raw[1] = 1'b0;
    dly_on[15 +: 15] = '0;
    @(negedge clk);

    // R9: delay above limit acts as 30000
    dly_on[0 +: 15] = 15'd32767;
    @(negedge clk) sw_raw[0] = 1'b1;
    ticks(29999);
    chk("R9 clamp before 30000", 7'h00);
    ticks(1);
    chk("R9 clamp at 30000", 7'b0000001);

    summary();
  end
endmodule